// File: doc/BRIEF.md
# Self-Test Engine with Pseudorandom Stimulus and Signature Compare

This block is a self-contained logic self-test engine. A start pulse seeds an 8-bit pseudorandom pattern generator and clears an 8-stage response compressor. For the next 255 clock cycles, each pattern drives one of two small built-in circuits under test. The first is a 3-to-8 line decoder and the second is a 4-bit adder. Every response is folded into the compressor.

When the run ends, the final signature is compared with a golden value that belongs to the selected circuit. The block then raises done together with exactly one of pass or fail. A fault-injection control holds one response bit at logic 1, so a known-bad run can be shown to fail. The circuit selection is captured when start is sampled. The verdict and the signature stay unchanged until the next start.

Top module: `lbist_engine`

## Requirements
- R1: While reset is asserted and right after it is released, done, pass and fail are low and signature is 8'h00.
- R2: The pattern generator loads 8'h01 on start. Each run cycle it steps to {p[6:0], p[7]^p[5]^p[4]^p[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. It never holds 8'h00.
- R3: done rises exactly 255 clock edges after the edge that samples start, and it stays low for the whole run.
- R4: When cut_sel is 0, the response is the one-hot decode of pattern bits [2:0]: bit n is set when p[2:0] equals n. Pattern bits [7:3] do not affect the response.
- R5: When cut_sel is 1, the response is p[3:0] + p[7:4] with carry-in 0. The 5-bit sum is placed in bits [4:0] and bits [7:5] are 0.
- R6: The compressor clears to 8'h00 on start. On each run cycle it takes the value {s[6:0], s[7]^s[5]^s[4]^s[3]} XOR response, using the pattern present before that edge.
- R7: While done is high, pass is 1 when signature equals the golden value for the captured circuit, and fail is 1 otherwise. pass and fail are never both 1, and both are 0 while done is low.
- R8: When fault_inj is 1, response bit 0 is forced to 1. A run with the fault whose signature differs from the golden value reports fail.
- R9: After done rises, done, signature, pass and fail hold their values until the next start. That start clears done and signature in the next cycle.
- R10: A start sampled during a run, including on the final run edge, restarts the run from the seed. done then rises 255 edges after the new start.
- R11: A change of cut_sel after start has been sampled has no effect on the run in progress or on its verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins (or restarts) a self-test run |
| cut_sel | input | 1 | Circuit select: 0 decoder, 1 adder |
| fault_inj | input | 1 | Forces response bit 0 to 1 |
| done | output | 1 | Run complete, verdict valid |
| pass | output | 1 | Signature matched golden value |
| fail | output | 1 | Signature mismatched golden value |
| signature | output | 8 | Compressor contents |

## Verification
Two events can fall in the same cycle: a fresh start and the final compression edge of the current run. The bench provokes this by asserting start so that it is sampled on exactly the 255th edge after the previous start. It then judges that done never rises for the abandoned run. It also judges that done rises 255 edges after the new start, with a signature equal to the independently computed fault-free value. A second overlap is a start that lands while an earlier verdict is being held. That start must clear done and the signature in the very next cycle.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int LB_W    = 8;
  localparam int LB_H    = LB_W / 2;
  localparam int LB_SELW = $clog2(LB_W);
  localparam logic [LB_W-1:0] LB_TAPS = 8'hB8;
  localparam logic [LB_W-1:0] LB_SEED = 8'h01;
  localparam int LB_RUN  = (1 << LB_W) - 1;

  typedef enum logic {CUT_DEC = 1'b0, CUT_ADD = 1'b1} cut_mode_e;

  function automatic logic [LB_W-1:0] lb_step(input logic [LB_W-1:0] s);
    return {s[LB_W-2:0], ^(s & LB_TAPS)};
  endfunction

  function automatic logic [LB_W-1:0] lb_fold(input logic [LB_W-1:0] s,
                                              input logic [LB_W-1:0] r);
    return lb_step(s) ^ r;
  endfunction

  function automatic logic [LB_W-1:0] lb_add(input logic [LB_W-1:0] p);
    logic [LB_W-1:0] r;
    r = '0;
    r[LB_H:0] = {1'b0, p[LB_H-1:0]} + {1'b0, p[LB_W-1:LB_H]};
    return r;
  endfunction

  function automatic logic [LB_W-1:0] lb_dec(input logic [LB_W-1:0] p);
    logic [LB_W-1:0] r;
    r = '0;
    r[p[LB_SELW-1:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [LB_W-1:0] lb_golden(input logic mode);
    logic [LB_W-1:0] p;
    logic [LB_W-1:0] s;
    p = LB_SEED;
    s = '0;
    for (int i = 0; i < LB_RUN; i++) begin
      s = lb_fold(s, mode ? lb_add(p) : lb_dec(p));
      p = lb_step(p);
    end
    return s;
  endfunction
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
  import lbist_pkg::*;
#(
  parameter int W = LB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] pattern
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pattern <= LB_SEED;
    else if (load) pattern <= LB_SEED;
    else if (adv)  pattern <= lb_step(pattern);
  end
endmodule

// File: rtl/lbist_cut.sv
module lbist_cut
  import lbist_pkg::*;
#(
  parameter int W    = LB_W,
  parameter int SELW = $clog2(W)
) (
  input  cut_mode_e    mode,
  input  logic         fault,
  input  logic [W-1:0] pattern,
  output logic [W-1:0] resp
);
  logic [W-1:0] dec_out;
  logic [W-1:0] add_out;
  logic [W-1:0] raw;

  for (genvar g = 0; g < W; g++) begin : g_dec
    assign dec_out[g] = (pattern[SELW-1:0] == SELW'(g));
  end

  assign add_out = lb_add(pattern);
  assign raw     = (mode == CUT_ADD) ? add_out : dec_out;

  always_comb begin
    resp = raw;
    if (fault) resp[0] = 1'b1;
  end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
  import lbist_pkg::*;
#(
  parameter int W = LB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (adv)   sig <= lb_fold(sig, resp);
  end
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int RUN = LB_RUN,
  parameter int CW  = $clog2(RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sel_in,
  output logic          running,
  output logic          last,
  output logic          done,
  output logic [CW-1:0] cnt,
  output cut_mode_e     mode_q
);
  assign last = running && (cnt == CW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      mode_q  <= CUT_DEC;
    end else if (start) begin
      running <= 1'b1;
      done    <= 1'b0;
      cnt     <= '0;
      mode_q  <= cut_mode_e'(sel_in);
    end else if (running) begin
      if (last) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
  import lbist_pkg::*;
#(
  parameter logic [LB_W-1:0] EXP_DEC = lb_golden(1'b0),
  parameter logic [LB_W-1:0] EXP_ADD = lb_golden(1'b1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cut_sel,
  input  logic            fault_inj,
  output logic            done,
  output logic            pass,
  output logic            fail,
  output logic [LB_W-1:0] signature
);
  localparam int CW = $clog2(LB_RUN + 1);

  logic            running;
  logic            last;
  logic [CW-1:0]   cnt;
  cut_mode_e       mode_q;
  logic            step;
  logic [LB_W-1:0] pattern;
  logic [LB_W-1:0] resp;
  logic [LB_W-1:0] golden;
  logic            sig_match;

  assign step = running && !start;

  lbist_seq #(.RUN(LB_RUN), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_in(cut_sel),
    .running(running), .last(last), .done(done), .cnt(cnt), .mode_q(mode_q)
  );

  lbist_prpg #(.W(LB_W)) u_prpg (
    .clk(clk), .rst_n(rst_n), .load(start), .adv(step), .pattern(pattern)
  );

  lbist_cut #(.W(LB_W)) u_cut (
    .mode(mode_q), .fault(fault_inj), .pattern(pattern), .resp(resp)
  );

  lbist_misr #(.W(LB_W)) u_misr (
    .clk(clk), .rst_n(rst_n), .clear(start), .adv(step), .resp(resp),
    .sig(signature)
  );

  assign golden    = (mode_q == CUT_ADD) ? EXP_ADD : EXP_DEC;
  assign sig_match = (signature == golden);
  assign pass      = done && sig_match;
  assign fail      = done && !sig_match;
endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk #(
  parameter int W   = 8,
  parameter int CW  = 8,
  parameter int RUN = 255
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [W-1:0]  signature,
  input logic [W-1:0]  pattern,
  input logic          running,
  input logic          last,
  input logic [CW-1:0] cnt
);
  a_r2_pattern_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    pattern != '0);

  a_r3_quiet_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !done);

  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> done);

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < RUN);

  a_r7_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  a_r7_verdict_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> done);

  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(signature) && $stable(pass)));

  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && !done && signature == '0));
endmodule

bind lbist_engine lbist_engine_chk #(.W(lbist_pkg::LB_W), .CW(CW), .RUN(lbist_pkg::LB_RUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
  .fail(fail), .signature(signature), .pattern(pattern), .running(running),
  .last(last), .cnt(cnt)
);

// File: tb/lbist_engine_test.sv
module lbist_engine_test;
  function automatic logic [7:0] m_next(input logic [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  function automatic logic [7:0] m_resp(input logic md, input logic flt,
                                        input logic [7:0] p);
    logic [7:0] r;
    if (md) r = {3'b000, {1'b0, p[3:0]} + {1'b0, p[7:4]}};
    else    r = 8'h01 << p[2:0];
    if (flt) r = r | 8'h01;
    return r;
  endfunction

  function automatic logic [7:0] m_sig(input logic md, input logic flt);
    logic [7:0] p;
    logic [7:0] s;
    p = 8'h01;
    s = 8'h00;
    repeat (255) begin
      s = m_next(s) ^ m_resp(md, flt, p);
      p = m_next(p);
    end
    return s;
  endfunction

  localparam logic [7:0] GOLD_DEC = m_sig(1'b0, 1'b0);
  localparam logic [7:0] GOLD_ADD = m_sig(1'b1, 1'b0);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cut_sel = 1'b0;
  logic       fault_inj = 1'b0;
  logic       done, pass, fail;
  logic [7:0] signature;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  lbist_engine #(.EXP_DEC(GOLD_DEC), .EXP_ADD(GOLD_ADD)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cut_sel(cut_sel),
    .fault_inj(fault_inj), .done(done), .pass(pass), .fail(fail),
    .signature(signature)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 1;
    @(posedge clk); @(negedge clk);
    while (!done && n < 600) begin
      n++;
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done == 0 && pass == 0 && fail == 0, "R1 flags in reset", {done, pass, fail}, 0);
    check(signature == 8'h00, "R1 signature in reset", signature, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 0 && pass == 0 && fail == 0 && signature == 0,
          "R1 after release", {done, pass, fail, signature}, 0);
  endtask

  task automatic t_run(input logic md, input logic flt, input string tag);
    int n;
    logic [7:0] exp_s;
    bit exp_pass;
    exp_s = m_sig(md, flt);
    exp_pass = (exp_s == (md ? GOLD_ADD : GOLD_DEC));
    cut_sel = md;
    fault_inj = flt;
    pulse_start();
    wait_done(n);
    check(n == 255, {"R3 run length ", tag}, n, 255);
    check(signature == exp_s, {tag, " signature R2 R6"}, signature, exp_s);
    check(pass == exp_pass && fail == !exp_pass, {tag, " verdict R7"},
          {pass, fail}, {exp_pass, !exp_pass});
    fault_inj = 1'b0;
  endtask

  task automatic t_fault(input logic md);
    logic [7:0] s;
    s = m_sig(md, 1'b1);
    t_run(md, 1'b1, md ? "R8 R5 adder fault" : "R8 R4 decoder fault");
    if (s != (md ? GOLD_ADD : GOLD_DEC))
      check(fail == 1 && pass == 0, "R8 fault flagged", {pass, fail}, 1);
  endtask

  task automatic t_hold();
    logic [7:0] s0;
    logic p0;
    s0 = signature;
    p0 = pass;
    cut_sel = ~cut_sel;
    fault_inj = 1'b1;
    repeat (20) @(negedge clk);
    check(done == 1 && signature == s0 && pass == p0, "R9 result held",
          {done, pass, signature}, {1'b1, p0, s0});
    fault_inj = 1'b0;
    pulse_start();
    check(done == 0 && signature == 8'h00, "R9 R10 start clears",
          {done, signature}, 0);
    repeat (300) @(negedge clk);
  endtask

  task automatic t_restart_last();
    int n;
    bit early;
    cut_sel = 1'b1;
    pulse_start();
    early = 1'b0;
    for (int i = 1; i < 254; i++) begin
      @(posedge clk); @(negedge clk);
      if (done) early = 1'b1;
    end
    @(posedge clk); @(negedge clk);
    if (done) early = 1'b1;
    check(!early, "R3 no done before last edge", early, 0);
    pulse_start();
    check(done == 0, "R10 restart on final edge suppresses done", done, 0);
    wait_done(n);
    check(n == 255, "R10 length after restart", n, 255);
    check(signature == GOLD_ADD && pass == 1, "R10 signature after restart",
          signature, GOLD_ADD);
  endtask

  task automatic t_sel_change();
    int n;
    cut_sel = 1'b0;
    pulse_start();
    repeat (100) @(negedge clk);
    cut_sel = 1'b1;
    wait_done(n);
    check(signature == GOLD_DEC && pass == 1 && fail == 0,
          "R11 select change ignored", signature, GOLD_DEC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run(1'b0, 1'b0, "R4 decoder");
    t_hold();
    t_run(1'b1, 1'b0, "R5 adder");
    t_fault(1'b0);
    t_fault(1'b1);
    t_restart_last();
    t_sel_change();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule